// File: doc/BRIEF.md
# Shifted-Operand Accumulator Adder

This block is a 32-bit accumulator datapath. On a start strobe it captures a 16-bit operand, extends it to 32 bits by sign or by zero, shifts it left by 0 to 16 places with zeros filling the low end, and adds it to the accumulator. The add updates four status flags: zero, negative, carry and overflow. It also updates a small signed counter that records positive and negative overflows. When saturation is enabled, an overflowing result is clamped to the largest or smallest 32-bit signed value.

A repeat count asks for the same add to run again, once per clock. With a count of N, N+1 adds take place back to back. The overflow flag and the overflow counter gather information from every intermediate add. The zero, negative and carry flags describe only the last add. A busy output covers the whole run, and a one-cycle done pulse marks its end. A separate clear input resets the overflow counter.

Top module: `shift_acc_adder`

## Requirements
- R1: The operand is shifted left by `shiftAmt` places and the vacated low bits are zero. A `shiftAmt` above 16 acts exactly as 16.
- R2: With `signExt`=1 the operand is sign-extended to 32 bits before the shift. With `signExt`=0 it is zero-extended.
- R3: After each run, `flagZ` is 1 exactly when `acc` is zero, and `flagN` equals `acc[31]`. Both reflect the value held in `acc`, which is the saturated value when saturation applied.
- R4: `flagC` takes the carry out of bit 31 of the last add. When the shift is 16, the carry can set `flagC` but never clears it.
- R5: `flagV` is set by any signed overflow of any add in a run. No add ever clears it. A positive overflow means two non-negative values gave a negative sum; a negative overflow means two negative values gave a non-negative sum.
- R6: With `satMode`=1, a positive overflow loads 0x7FFFFFFF and a negative overflow loads 0x80000000.
- R7: With `satMode`=0, each positive overflow adds 1 to the 6-bit two's-complement `ovCount` and each negative overflow subtracts 1, wrapping modulo 64. With `satMode`=1, `ovCount` does not change.
- R8: A `repeatCnt` of N performs the add N+1 times, one add per clock.
- R9: `start` with `busy`=0 raises `busy` on the next edge. `busy` stays high for N+1 cycles. `done` is then high for exactly one cycle while `busy` is low. A `start` seen while `busy`=1 is ignored.
- R10: Synchronous reset zeroes `acc`, all four flags and `ovCount`. `ovcClear` zeroes `ovCount` on the next edge and leaves `acc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| operand | input | 16 | Value to be added |
| shiftAmt | input | 5 | Left shift, 0 to 16 (larger values act as 16) |
| signExt | input | 1 | 1 = sign-extend, 0 = zero-extend |
| satMode | input | 1 | 1 = saturate on overflow and freeze the counter |
| repeatCnt | input | 4 | Number of extra adds |
| ovcClear | input | 1 | Clears the overflow counter |
| busy | output | 1 | High while adds are pending |
| done | output | 1 | One-cycle end-of-run pulse |
| acc | output | 32 | Accumulator |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Sticky overflow flag |
| ovCount | output | 6 | Signed overflow counter |

## Verification
Call the clock edge that accepts `start` edge k. The operand is captured on edge k, and the adds happen on edges k+1 through k+N+1. `busy` rises after edge k, and `done` and the final `acc`, flags and counter all appear after edge k+N+1. The bench drives inputs and samples outputs on falling edges, and counts the falling edges that show `busy` high until `done` appears. It expects exactly N+1 such edges, and checks every result at the `done` edge against its own model. It checks `done` again one cycle later, and checks an `ovcClear` result one edge after the clear.

// File: rtl/sacc_pkg.sv
package sacc_pkg;
  // Strobes from sequencing control to the arithmetic datapath.
  typedef struct packed {
    logic load;  // capture the extended, shifted operand
    logic step;  // perform one add this cycle
  } saccStrobe_t;
endpackage

// File: rtl/sacc_ctrl.sv
module sacc_ctrl
  import sacc_pkg::*;
#(
  parameter int RPT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [RPT_W-1:0] repeatCnt,
  output saccStrobe_t      strobes,
  output logic             busy,
  output logic             done
);
  logic [RPT_W-1:0] remaining;

  always_comb begin
    strobes.load = start & ~busy;
    strobes.step = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        busy      <= 1'b1;
        remaining <= repeatCnt;
      end else if (busy) begin
        if (remaining == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          remaining <= remaining - RPT_W'(1);
        end
      end
    end
  end

  // R9: done lasts one cycle and never overlaps busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  // R9: a start while busy does not reload the repeat counter
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && remaining != '0) |=> (remaining == $past(remaining) - RPT_W'(1)));
endmodule

// File: rtl/sacc_datapath.sv
module sacc_datapath
  import sacc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OP_W  = 16,
  parameter int SH_W  = 5,
  parameter int OVC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  saccStrobe_t      strobes,
  input  logic [OP_W-1:0]  operand,
  input  logic [SH_W-1:0]  shiftAmt,
  input  logic             signExt,
  input  logic             satMode,
  input  logic             ovcClear,
  output logic [ACC_W-1:0] acc,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC,
  output logic             flagV,
  output logic [OVC_W-1:0] ovCount
);
  localparam int EXT_W = ACC_W - OP_W;
  localparam logic [SH_W-1:0] MAX_SH = SH_W'(OP_W);
  localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] opReg;
  logic             satReg;
  logic             fullShReg;

  logic [SH_W-1:0]  effSh;
  logic [ACC_W-1:0] extOp;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] rawRes;
  logic [ACC_W-1:0] nextAcc;
  logic             posOv;
  logic             negOv;

  always_comb begin
    effSh   = (shiftAmt > MAX_SH) ? MAX_SH : shiftAmt;
    extOp   = {{EXT_W{signExt & operand[OP_W-1]}}, operand};
    sum     = {1'b0, acc} + {1'b0, opReg};
    rawRes  = sum[ACC_W-1:0];
    posOv   = ~acc[ACC_W-1] & ~opReg[ACC_W-1] &  rawRes[ACC_W-1];
    negOv   =  acc[ACC_W-1] &  opReg[ACC_W-1] & ~rawRes[ACC_W-1];
    nextAcc = rawRes;
    if (satReg && posOv) nextAcc = SAT_POS;
    if (satReg && negOv) nextAcc = SAT_NEG;
  end

  // Operand capture at the start of a run
  always_ff @(posedge clk) begin
    if (rst) begin
      opReg     <= '0;
      satReg    <= 1'b0;
      fullShReg <= 1'b0;
    end else if (strobes.load) begin
      opReg     <= extOp << effSh;
      satReg    <= satMode;
      fullShReg <= (effSh == MAX_SH);
    end
  end

  // Accumulator and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagC <= 1'b0;
      flagV <= 1'b0;
    end else if (strobes.step) begin
      acc   <= nextAcc;
      flagZ <= (nextAcc == '0);
      flagN <= nextAcc[ACC_W-1];
      flagC <= fullShReg ? (flagC | sum[ACC_W]) : sum[ACC_W];
      flagV <= flagV | posOv | negOv;
    end
  end

  // Overflow counter
  always_ff @(posedge clk) begin
    if (rst || ovcClear) begin
      ovCount <= '0;
    end else if (strobes.step && !satReg) begin
      if (posOv)      ovCount <= ovCount + OVC_W'(1);
      else if (negOv) ovCount <= ovCount - OVC_W'(1);
    end
  end

  // R5: the overflow flag is sticky
  assert_v_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    flagV |=> flagV);
  // R4: a full-width shift never clears carry
  assert_c_setonly_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && fullShReg && flagC) |=> flagC);
  // R7: the counter is frozen while saturating
  assert_ovc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && satReg && !ovcClear) |=> $stable(ovCount));
  // R6: a saturated result is one of the two limits
  assert_sat_limit_R6: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && satReg && (posOv || negOv)) |=>
      (acc == SAT_POS || acc == SAT_NEG));
  // R8: the accumulator only moves on an add step
  assert_acc_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !strobes.step |=> $stable(acc));
endmodule

// File: rtl/shift_acc_adder.sv
module shift_acc_adder
  import sacc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OP_W  = 16,
  parameter int SH_W  = 5,
  parameter int RPT_W = 4,
  parameter int OVC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [OP_W-1:0]  operand,
  input  logic [SH_W-1:0]  shiftAmt,
  input  logic             signExt,
  input  logic             satMode,
  input  logic [RPT_W-1:0] repeatCnt,
  input  logic             ovcClear,
  output logic             busy,
  output logic             done,
  output logic [ACC_W-1:0] acc,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagC,
  output logic             flagV,
  output logic [OVC_W-1:0] ovCount
);
  saccStrobe_t strobes;

  sacc_ctrl #(.RPT_W(RPT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .repeatCnt(repeatCnt),
    .strobes(strobes), .busy(busy), .done(done)
  );

  sacc_datapath #(.ACC_W(ACC_W), .OP_W(OP_W), .SH_W(SH_W), .OVC_W(OVC_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .operand(operand),
    .shiftAmt(shiftAmt), .signExt(signExt), .satMode(satMode),
    .ovcClear(ovcClear), .acc(acc), .flagZ(flagZ), .flagN(flagN),
    .flagC(flagC), .flagV(flagV), .ovCount(ovCount)
  );
endmodule

// File: tb/shift_acc_adder_bench.sv
module shift_acc_adder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] operand = '0;
  logic [4:0]  shiftAmt = '0;
  logic        signExt = 1'b0;
  logic        satMode = 1'b0;
  logic [3:0]  repeatCnt = '0;
  logic        ovcClear = 1'b0;
  logic        busy, done, flagZ, flagN, flagC, flagV;
  logic [31:0] acc;
  logic [5:0]  ovCount;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [31:0] mAcc;
  logic        mZ, mN, mC, mV;
  logic [5:0]  mOvc;

  always #2.5 clk = ~clk;  // 200 MHz

  shift_acc_adder u_shift_acc_adder (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .shiftAmt(shiftAmt),
    .signExt(signExt), .satMode(satMode), .repeatCnt(repeatCnt), .ovcClear(ovcClear),
    .busy(busy), .done(done), .acc(acc), .flagZ(flagZ), .flagN(flagN),
    .flagC(flagC), .flagV(flagV), .ovCount(ovCount)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, actual, expected);
    end
  endtask

  task automatic checkAll(input string req);
    checkVal(req, "acc", acc, mAcc);
    checkVal(req, "flagZ", 32'(flagZ), 32'(mZ));
    checkVal(req, "flagN", 32'(flagN), 32'(mN));
    checkVal(req, "flagC", 32'(flagC), 32'(mC));
    checkVal(req, "flagV", 32'(flagV), 32'(mV));
    checkVal(req, "ovCount", 32'(ovCount), 32'(mOvc));
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mAcc = '0; mZ = 0; mN = 0; mC = 0; mV = 0; mOvc = '0;
  endtask

  // Model of one run built from the requirements
  task automatic modelRun(input logic [15:0] op, input logic [4:0] sh, input logic sx,
                          input logic sat, input logic [3:0] rpt);
    logic [31:0] ext, addend, r;
    logic [32:0] s;
    logic p, n, full;
    int effSh;
    ext    = sx ? {{16{op[15]}}, op} : {16'h0, op};
    effSh  = (sh > 5'd16) ? 16 : int'(sh);
    full   = (effSh == 16);
    addend = ext << effSh;
    for (int i = 0; i <= int'(rpt); i++) begin
      s = {1'b0, mAcc} + {1'b0, addend};
      r = s[31:0];
      p = !mAcc[31] && !addend[31] && r[31];
      n = mAcc[31] && addend[31] && !r[31];
      if (sat && p) r = 32'h7FFF_FFFF;
      if (sat && n) r = 32'h8000_0000;
      mC = full ? (mC | s[32]) : s[32];
      mV = mV | p | n;
      if (!sat) begin
        if (p) mOvc = mOvc + 6'd1;
        else if (n) mOvc = mOvc - 6'd1;
      end
      mAcc = r;
      mZ = (r == 32'h0);
      mN = r[31];
    end
  endtask

  task automatic runOp(input string req, input logic [15:0] op, input logic [4:0] sh,
                       input logic sx, input logic sat, input logic [3:0] rpt,
                       input logic inject);
    int cycles = 0;
    @(negedge clk);
    operand = op; shiftAmt = sh; signExt = sx; satMode = sat; repeatCnt = rpt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    modelRun(op, sh, sx, sat, rpt);
    while (!done && cycles < 100) begin
      if (!busy) begin
        errors++;
        $display("FAIL R9 busy low before done actual=0 expected=1");
      end
      if (inject && cycles == 0) begin
        operand = 16'h5A5A; repeatCnt = 4'hF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      cycles++;
      @(negedge clk);
    end
    start = 1'b0;
    checkVal("R8", "busy cycles", 32'(cycles), 32'(int'(rpt) + 1));
    checkVal("R9", "busy at done", 32'(busy), 32'h0);
    checkAll(req);
    @(negedge clk);
    checkVal("R9", "done width", 32'(done), 32'h0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R10: reset state
    checkAll("R10");
    checkVal("R9", "busy after reset", 32'(busy), 32'h0);
    checkVal("R9", "done after reset", 32'(done), 32'h0);

    // R1: plain shift with zero fill
    runOp("R1", 16'h1234, 5'd4, 1'b0, 1'b0, 4'd0, 1'b0);
    // R2: sign extension, then zero extension of the same pattern
    runOp("R2", 16'h8000, 5'd0, 1'b1, 1'b0, 4'd0, 1'b0);
    runOp("R2", 16'h8000, 5'd0, 1'b0, 1'b0, 4'd0, 1'b0);
    // R1: shift above 16 clamps to 16
    runOp("R1", 16'h0003, 5'd20, 1'b0, 1'b0, 4'd0, 1'b0);

    // R3: result of zero sets Z, with carry out
    doReset();
    runOp("R3", 16'h0010, 5'd0, 1'b0, 1'b0, 4'd0, 1'b0);
    runOp("R3", 16'hFFF0, 5'd0, 1'b1, 1'b0, 4'd0, 1'b0);
    checkVal("R3", "Z on zero", 32'(flagZ), 32'h1);

    // R4: full shift sets carry but never clears it
    doReset();
    runOp("R4", 16'hFFFF, 5'd16, 1'b1, 1'b0, 4'd0, 1'b0);
    runOp("R4", 16'hFFFF, 5'd16, 1'b1, 1'b0, 4'd0, 1'b0);
    runOp("R4", 16'h0001, 5'd16, 1'b0, 1'b0, 4'd0, 1'b0);
    checkVal("R4", "C kept", 32'(flagC), 32'h1);
    // R4: a shift below 16 clears carry
    runOp("R4", 16'h0001, 5'd0, 1'b0, 1'b0, 4'd0, 1'b0);
    checkVal("R4", "C cleared", 32'(flagC), 32'h0);

    // R5 R7 R8: repeated positive overflows counted, V sticky
    doReset();
    runOp("R7", 16'h7FFF, 5'd16, 1'b1, 1'b0, 4'd3, 1'b0);
    checkVal("R7", "count up", 32'(ovCount), 32'h2);
    runOp("R5", 16'h0001, 5'd0, 1'b0, 1'b0, 4'd0, 1'b0);
    checkVal("R5", "V sticky", 32'(flagV), 32'h1);

    // R7: negative overflow wraps the counter below zero
    doReset();
    runOp("R7", 16'h8000, 5'd16, 1'b1, 1'b0, 4'd1, 1'b0);
    checkVal("R7", "wrap", 32'(ovCount), 32'h3F);

    // R10: clear counter, accumulator unchanged
    @(negedge clk);
    ovcClear = 1'b1;
    @(negedge clk);
    ovcClear = 1'b0;
    mOvc = '0;
    checkVal("R10", "ovc cleared", 32'(ovCount), 32'h0);
    checkVal("R10", "acc kept", acc, mAcc);

    // R6 R7: saturation at both limits, counter frozen
    doReset();
    runOp("R6", 16'h7FFF, 5'd16, 1'b1, 1'b1, 4'd5, 1'b0);
    checkVal("R6", "sat pos", acc, 32'h7FFF_FFFF);
    checkVal("R7", "frozen", 32'(ovCount), 32'h0);
    doReset();
    runOp("R6", 16'h8000, 5'd16, 1'b1, 1'b1, 4'd4, 1'b0);
    checkVal("R6", "sat neg", acc, 32'h8000_0000);

    // R9: start while busy is ignored (short and long runs)
    doReset();
    runOp("R9", 16'h0101, 5'd2, 1'b0, 1'b0, 4'd0, 1'b1);
    runOp("R9", 16'h0040, 5'd8, 1'b1, 1'b0, 4'd6, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule